// File: doc/BRIEF.md
# Local Countdown Timer with Prescaler and Expiry Delivery

This block is a down-counting interval timer that runs from the bus clock through a power-of-two prescaler. Software programs a divide code, loads an initial count, and picks one-shot or periodic behaviour in the timer's interrupt entry. Each time the count reaches zero the block records one expiry in a small pending counter. It offers that expiry to the interrupt controller as a valid/ready request that carries the entry's vector.

The block also holds six interrupt entries, each with a vector, a mask and a mode bit. Entry 0 belongs to the timer. A global software enable gates delivery, and clearing it masks every entry. Register writes arrive on a simple write strobe with a 4-bit register select. The current count, the pending count and the entry masks are visible on output ports.

Top module: `irq_countdown_timer`

## Requirements
- R1: The divisor is 1 << ((({cfg[3],cfg[1],cfg[0]}) + 1) mod 8), so code 0 gives 2, 0xB gives 1, 0x7 gives 16, 0x8 gives 32 and 0xA gives 128. Bit 2 of the divide register has no effect. The divide register is select 0 and keeps wr_data[3:0].
- R2: The current count drops by exactly one every divisor bus-clock cycles. After an initial-count write at edge E, the first decrement happens at edge E+divisor.
- R3: A write to the initial-count register (select 1) sets the current count to wr_data[CNT_W-1:0] on the same edge, restarts the prescaler phase and clears the pending count.
- R4: An initial count of zero leaves the timer stopped, and the current count then reads 0.
- R5: In one-shot mode (entry 0 bit 17 = 0) the count stops at 0 on the edge where it would go from 1 to 0. That edge adds one pending expiry.
- R6: In periodic mode (entry 0 bit 17 = 1) the count reloads the initial count on that edge instead of stopping. Every reload adds one pending expiry.
- R7: irq_valid is high when the pending count is nonzero, entry 0 is unmasked and the software enable is set. irq_vector is then entry 0 bits [7:0]. Each cycle with irq_valid and irq_ready both high lowers the pending count by one.
- R8: The pending count saturates at 2^PEND_W-1.
- R9: Writing the control register (select 2) with bit 0 = 0 sets the mask of all entries and clears the pending count. While the enable is 0, any entry write (selects 3 to 8, mask in bit 16) leaves the mask set.
- R10: A divide-register write during a countdown does not restart the count. The new divisor applies from the next prescaler rollover onward.
- R11: After reset every entry is masked, the enable is 0, the divide code and the initial count are 0, the divisor is 2, and the current and pending counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select: 0 divide, 1 initial count, 2 control, 3+i entry i |
| wr_data | input | 32 | Write data |
| irq_ready | input | 1 | Controller accepts the offered expiry |
| irq_valid | output | 1 | Expiry offered to the controller |
| irq_vector | output | 8 | Vector of the timer entry |
| cur_count | output | CNT_W | Current count |
| pend_count | output | PEND_W | Expiries not yet delivered |
| entry_masked | output | NUM_ENTRIES | Mask bit of each entry |

## Verification
The bench covers four groups of cases.

- **Divide decoding.** It hits the split divide field with and without bit 2 set and includes the divide-by-one code. A design that read bits [2:0], or that did not wrap the sum, would count at the wrong rate.
- **Writes during a countdown.** It rewrites the initial count in mid-count with an expiry already pending, writes a zero count, and changes the divide code in mid-count. A design that failed here would keep a stale pending expiry, show a nonzero count while stopped, or restart the countdown on a divide write.
- **Pending and delivery.** It saturates the pending counter with a divide-by-one periodic count of one. It checks that one handshake removes exactly one expiry.
- **Disable and masking.** It clears the software enable while all entries are unmasked. It then tries to unmask an entry while the enable is off.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int VEC_W = 8;
  localparam int DIV_W = 8;

  localparam logic [3:0] ADDR_DIV  = 4'd0;
  localparam logic [3:0] ADDR_INIT = 4'd1;
  localparam logic [3:0] ADDR_CTRL = 4'd2;
  localparam logic [3:0] ADDR_ENT0 = 4'd3;

  localparam int F_MASK     = 16;
  localparam int F_PERIODIC = 17;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // divisor from the split field {cfg[3],cfg[1],cfg[0]}
  function automatic logic [DIV_W-1:0] decode_div(input logic [3:0] cfg);
    logic [2:0] sh;
    sh = {cfg[3], cfg[1], cfg[0]} + 3'd1;
    return DIV_W'(1) << sh;
  endfunction
endpackage

// File: rtl/irq_timer_prescaler.sv
module irq_timer_prescaler
  import irq_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] div_cfg,
  output logic       tick
);
  logic [DIV_W-1:0] presc;
  logic [DIV_W-1:0] div_act;
  logic [DIV_W-1:0] div_new;

  assign div_new = decode_div(div_cfg);
  assign tick    = run && (presc == div_act - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      presc   <= '0;
      div_act <= decode_div(4'd0);
    end else if (restart || !run || tick) begin
      presc   <= '0;
      div_act <= div_new;
    end else begin
      presc <= presc + DIV_W'(1);
    end
  end

  // the phase counter never passes the active divisor
  assert_presc_range_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> (presc < div_act));

  // a new divisor is only taken at a rollover or restart
  assert_div_at_rollover_R10: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !tick) |=> $stable(div_act));
endmodule

// File: rtl/irq_timer_counter.sv
module irq_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  assign expire = running && tick && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      running <= (load_val != '0);
    end else if (running && tick) begin
      if (cnt == CNT_W'(1)) begin
        if (periodic) begin
          cnt <= reload_val;
        end else begin
          cnt     <= '0;
          running <= 1'b0;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assert_idle_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !running |-> (cnt == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic) |=> !running);

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic) |=> (cnt == $past(reload_val)));
endmodule

// File: rtl/irq_timer_pending.sv
module irq_timer_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              expire,
  input  logic              deliver,
  output logic [PEND_W-1:0] pend
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend <= '0;
    end else begin
      unique case ({expire, deliver})
        2'b10:   if (pend != PMAX) pend <= pend + PEND_W'(1);
        2'b01:   if (pend != '0)   pend <= pend - PEND_W'(1);
        default: pend <= pend;
      endcase
    end
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pend == '0));

  assert_deliver_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (deliver && !expire && !clear && pend != '0) |=> (pend == $past(pend) - PEND_W'(1)));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (pend == PMAX && expire && !deliver && !clear) |=> (pend == PMAX));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import irq_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PEND_W      = 4,
  parameter int NUM_ENTRIES = 6,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [3:0]             wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   irq_ready,
  output logic                   irq_valid,
  output logic [VEC_W-1:0]       irq_vector,
  output logic [CNT_W-1:0]       cur_count,
  output logic [PEND_W-1:0]      pend_count,
  output logic [NUM_ENTRIES-1:0] entry_masked
);
  logic [3:0]       div_cfg;
  logic [CNT_W-1:0] init_val;
  logic             sw_en;
  logic             load;
  logic             dis_wr;
  logic             tick;
  logic             running;
  logic             expire;
  logic             deliver;
  entry_t           tmr_ent;

  assign load   = wr_en && (wr_addr == ADDR_INIT);
  assign dis_wr = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cfg  <= '0;
      init_val <= '0;
      sw_en    <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_DIV)  div_cfg  <= wr_data[3:0];
      if (wr_addr == ADDR_INIT) init_val <= wr_data[CNT_W-1:0];
      if (wr_addr == ADDR_CTRL) sw_en    <= wr_data[0];
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    entry_t ent_q;
    logic   hit;
    assign hit = wr_en && (wr_addr == 4'(ADDR_ENT0 + g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
      end else if (dis_wr) begin
        ent_q.masked <= 1'b1;
      end else if (hit) begin
        ent_q.vector   <= wr_data[VEC_W-1:0];
        ent_q.masked   <= wr_data[F_MASK] | !sw_en;
        ent_q.periodic <= (g == 0) ? wr_data[F_PERIODIC] : 1'b0;
      end
    end

    assign entry_masked[g] = ent_q.masked;
  end

  assign tmr_ent = g_ent[0].ent_q;

  irq_timer_prescaler u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .restart (load),
    .div_cfg (div_cfg),
    .tick    (tick)
  );

  irq_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (init_val),
    .periodic   (tmr_ent.periodic),
    .tick       (tick),
    .cnt        (cur_count),
    .running    (running),
    .expire     (expire)
  );

  irq_timer_pending #(.PEND_W(PEND_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .clear   (load || dis_wr),
    .expire  (expire),
    .deliver (deliver),
    .pend    (pend_count)
  );

  assign irq_valid  = sw_en && !tmr_ent.masked && (pend_count != '0);
  assign irq_vector = tmr_ent.vector;
  assign deliver    = irq_valid && irq_ready;

  assert_disabled_masked_R9: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> (&entry_masked));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    dis_wr |=> ((pend_count == '0) && (&entry_masked)));

  assert_init_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_count == $past(wr_data[CNT_W-1:0])));
endmodule

// File: tb/irq_countdown_timer_bench.sv
module irq_countdown_timer_bench;
  localparam int CNT_W = 32;
  localparam int PEND_W = 4;
  localparam int NE = 6;
  localparam longint PMAX = 15;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, wr_en, irq_ready, irq_valid;
  logic [3:0] wr_addr;
  logic [31:0] wr_data;
  logic [7:0] irq_vector;
  logic [CNT_W-1:0] cur_count;
  logic [PEND_W-1:0] pend_count;
  logic [NE-1:0] entry_masked;

  int checks = 0;
  int fails = 0;

  irq_countdown_timer u_irq_countdown_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ready(irq_ready), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .cur_count(cur_count), .pend_count(pend_count), .entry_masked(entry_masked)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint div_of(input logic [3:0] cfg);
    int sh;
    sh = (({29'd0, cfg[3], cfg[1], cfg[0]}) + 1) % 8;
    return longint'(1) << sh;
  endfunction

  function automatic longint exp_cnt(input longint n, input longint d, input longint m, input bit per);
    longint steps;
    if (n == 0) return 0;
    steps = m / d;
    if (!per) return (steps >= n) ? 0 : n - steps;
    return n - (steps % n);
  endfunction

  function automatic longint exp_pend(input longint n, input longint d, input longint m, input bit per);
    longint e;
    if (n == 0) return 0;
    if (!per) e = ((m / d) >= n) ? 1 : 0;
    else e = (m / d) / n;
    return (e > PMAX) ? PMAX : e;
  endfunction

  function automatic logic [31:0] ent_word(input bit per, input bit msk, input logic [7:0] v);
    return {14'd0, per, msk, 8'd0, v};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0] cfgs [5];
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; irq_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11", "count", cur_count, 0);
    check("R11", "pending", pend_count, 0);
    check("R11", "masks", entry_masked, 6'h3F);
    check("R11", "valid", irq_valid, 0);

    // R11/R2 default divisor 2
    wr(4'd1, 32'd4);
    wait_n(7);
    check("R2", "count before last step", cur_count, 1);
    wait_n(1);
    check("R5", "one-shot end", cur_count, 0);
    check("R5", "one expiry", pend_count, 1);
    wait_n(6);
    check("R5", "stays stopped", cur_count, 0);

    // R4 zero initial count
    wr(4'd1, 32'd5);
    wait_n(3);
    wr(4'd1, 32'd0);
    check("R4", "zero count", cur_count, 0);
    check("R4", "pending cleared", pend_count, 0);
    wait_n(20);
    check("R4", "still zero", cur_count, 0);
    check("R4", "no expiry", pend_count, 0);

    // R3 rewrite mid-flight clears pending and restarts the phase
    wr(4'd1, 32'd3);
    wait_n(10);
    check("R3", "pending before rewrite", pend_count, 1);
    wr(4'd1, 32'd20);
    check("R3", "loaded", cur_count, 20);
    check("R3", "pending cleared", pend_count, 0);
    wait_n(3);
    wr(4'd1, 32'd20);
    wait_n(1);
    check("R3", "phase restarted", cur_count, 20);
    wait_n(3);
    check("R3", "after restart", cur_count, 18);

    // R10 divide change mid-count
    wr(4'd1, 32'd10);
    wr(4'd0, 32'h0000_000B);
    check("R10", "no restart on divide write", cur_count, 10);
    wait_n(1);
    check("R10", "old rollover", cur_count, 9);
    wait_n(4);
    check("R10", "new divisor", cur_count, 5);

    // R1 decoding of the split field
    cfgs[0] = 4'hB; cfgs[1] = 4'h4; cfgs[2] = 4'h7; cfgs[3] = 4'h8; cfgs[4] = 4'hA;
    for (int i = 0; i < 5; i++) begin
      longint d;
      d = div_of(cfgs[i]);
      wr(4'd0, {28'd0, cfgs[i]});
      wr(4'd1, 32'd3);
      wait_n(int'(3 * d - 1));
      check("R1", $sformatf("cfg %0h before end", cfgs[i]), cur_count, 1);
      wait_n(1);
      check("R1", $sformatf("cfg %0h end", cfgs[i]), cur_count, 0);
    end

    // R6/R8 periodic saturation
    wr(4'd3, ent_word(1'b1, 1'b1, 8'h00));
    wr(4'd0, 32'h0000_000B);
    wr(4'd1, 32'd1);
    wait_n(40);
    check("R8", "saturated", pend_count, PMAX);
    check("R6", "reload of 1", cur_count, 1);

    // R7 delivery
    wr(4'd2, 32'd1);
    wr(4'd3, ent_word(1'b0, 1'b0, 8'h5A));
    wr(4'd1, 32'd3);
    wait_n(2);
    check("R7", "no valid before expiry", irq_valid, 0);
    wait_n(1);
    check("R7", "pending", pend_count, 1);
    check("R7", "valid", irq_valid, 1);
    check("R7", "vector", irq_vector, 8'h5A);
    irq_ready = 1'b1;
    wait_n(1);
    check("R7", "delivered", pend_count, 0);
    check("R7", "valid drops", irq_valid, 0);
    irq_ready = 1'b0;

    // R9 disable forces masks
    for (int g = 0; g < NE; g++) wr(4'(3 + g), ent_word(1'b0, 1'b0, 8'(g)));
    check("R9", "all unmasked", entry_masked, 0);
    wr(4'd3, ent_word(1'b1, 1'b0, 8'h21));
    wr(4'd1, 32'd1);
    wait_n(5);
    check("R6", "periodic pending", pend_count, 5);
    wr(4'd2, 32'd0);
    check("R9", "masks forced", entry_masked, 6'h3F);
    check("R9", "pending cleared", pend_count, 0);
    wr(4'd3, ent_word(1'b1, 1'b0, 8'h21));
    check("R9", "mask kept while disabled", entry_masked[0], 1);
    check("R9", "no valid", irq_valid, 0);

    // random runs against the model (R1, R2, R5, R6, R8)
    for (int it = 0; it < 24; it++) begin
      logic [3:0] cfg;
      longint n, d, m, lim;
      bit per;
      cfg = 4'($urandom_range(0, 15));
      n = longint'($urandom_range(1, 40));
      per = 1'($urandom_range(0, 1));
      d = div_of(cfg);
      lim = n * d * 3;
      if (lim > 1500) lim = 1500;
      m = longint'($urandom_range(0, int'(lim)));
      wr(4'd3, ent_word(per, 1'b1, 8'h33));
      wr(4'd0, {28'd0, cfg});
      wr(4'd1, 32'(n));
      wait_n(int'(m));
      check("R2", $sformatf("rand %0d count", it), cur_count, exp_cnt(n, d, m, per));
      check("R6", $sformatf("rand %0d pending", it), pend_count, exp_pend(n, d, m, per));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule